// File: doc/BRIEF.md
# Privileged Operation Violation Checker

This block sits beside an instruction decoder and decides, for each issued operation, whether the operation may proceed at the current privilege level. Level 0 is the kernel level and level 3 is the user level. An operation faults whenever the current level is numerically above the level the operation requires. A fault is reported with the general-protection exception vector and a zero error code. The exception entry itself happens elsewhere.

I/O port operations get two chances before they fault. They pass if the current level does not exceed the I/O privilege level. If that compare fails, they can still pass through a per-port permission bitmap. The checker drives the bitmap's read address and receives a 16-bit window of permission bits through a combinational read port. A flags-restore operation never faults. Below level 0 it keeps the interrupt-enable bit at its present value and writes every other bit from the restored value.

Each decision is registered and appears one cycle after the input-valid strobe.

Top module: `priv_op_checker`

## Requirements
- R1: Operation class codes 2 (interrupt enable/disable), 3 (descriptor table load), 5 (control register access), 6 (model-specific register access), 7 (cache/TLB invalidate), 8 (halt) and 9 (clear task-switched) are allowed at level 0 and fault at levels 1, 2 and 3.
- R2: A faulting decision carries `vector` = 13 and `err_code` = 0. A decision that allows the operation carries `vector` = 0.
- R3: An I/O operation (class code 10) is allowed whenever `cur_lvl` <= `io_lvl`.
- R4: When `cur_lvl` > `io_lvl`, an I/O operation is allowed only if every bitmap bit covering the accessed ports is 0; a 1 denies the access. `pbm_addr` = `io_port[15:3]`. Bit k of `pbm_data` is the bit for port `pbm_addr*8 + k`. `io_size` codes 0, 1, 2 and 3 cover 1, 2, 4 and 4 ports, starting at bit `io_port[2:0]`. An access may cross into the second byte of the window.
- R5: A descriptor table store (class code 4) is allowed at every level.
- R6: A flags restore (class code 11) is allowed at every level and raises `flags_wr`. At level 0, `flags_out` equals `flags_src`. At levels 1 to 3, `flags_out` equals `flags_src` except bit 9 (interrupt enable), which is taken from `flags_cur`.
- R7: Ordinary computation classes, code 0 (arithmetic/logic) and code 1 (branch), are allowed at every level.
- R8: The unassigned class codes 12 to 15 are treated as privileged: they are allowed at level 0 and fault otherwise.
- R9: `out_valid`, `allow` and `fault` go high one cycle after `in_valid`. Exactly one of `allow` and `fault` is high with `out_valid`. In a cycle that follows no strobe, all three are low and `flags_wr` is 0.
- R10: After reset, `out_valid`, `allow`, `fault` and `flags_wr` are 0 and `vector` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_class | input | 4 | Decoded operation class code |
| cur_lvl | input | 2 | Current privilege level, 0 = kernel, 3 = user |
| io_lvl | input | 2 | I/O privilege level field |
| io_port | input | 16 | Port number of an I/O operation |
| io_size | input | 2 | I/O access width code (1, 2, 4, 4 ports) |
| pbm_addr | output | 13 | Permission bitmap byte address |
| pbm_data | input | 16 | Bitmap bytes at pbm_addr and pbm_addr+1 |
| flags_cur | input | 16 | Present flags value |
| flags_src | input | 16 | Flags value a restore operation would write |
| out_valid | output | 1 | Decision valid |
| allow | output | 1 | Operation may proceed |
| fault | output | 1 | Operation raises an exception |
| vector | output | 8 | Exception vector, 0 when no fault |
| err_code | output | 16 | Exception error code |
| flags_wr | output | 1 | A masked flags value is to be written |
| flags_out | output | 16 | Masked flags value |

## Verification
On every cycle, the assertions check these properties:
- Every decision is either allow or fault, never both.
- A fault always carries vector 13 and error code 0, and an allow carries vector 0.
- Every operation issued at level 0 is allowed.
- Descriptor table stores and flags restores never fault.
- The interrupt-enable bit survives a flags restore made below level 0.

Only the bench's scenarios show which classes are privileged and how the I/O level compare and the bitmap interact. This covers granted and denied ports, multi-port accesses that cross a byte of the window, and the bitmap address the block drives.

// File: rtl/priv_chk_pkg.sv
package priv_chk_pkg;
    typedef enum logic [3:0] {
        OPC_ALU       = 4'd0,
        OPC_BRANCH    = 4'd1,
        OPC_INT_CTL   = 4'd2,
        OPC_DT_LOAD   = 4'd3,
        OPC_DT_STORE  = 4'd4,
        OPC_CR_ACC    = 4'd5,
        OPC_MSR_ACC   = 4'd6,
        OPC_CACHE_INV = 4'd7,
        OPC_HALT      = 4'd8,
        OPC_CLR_TS    = 4'd9,
        OPC_IO        = 4'd10,
        OPC_FLAGS_RST = 4'd11
    } op_class_e;

    localparam int unsigned GP_VECTOR = 13;
    localparam int unsigned GP_ERROR  = 0;
endpackage

// File: rtl/priv_class_rule.sv
// Classifies an operation as kernel-only, I/O, or unrestricted.
module priv_class_rule
    import priv_chk_pkg::*;
(
    input  logic [3:0] op_class,
    output logic       kernel_only,
    output logic       is_io,
    output logic       is_flags_rst
);
    always_comb begin
        kernel_only  = 1'b0;
        is_io        = 1'b0;
        is_flags_rst = 1'b0;
        case (op_class)
            OPC_ALU, OPC_BRANCH, OPC_DT_STORE: kernel_only = 1'b0;
            OPC_INT_CTL, OPC_DT_LOAD, OPC_CR_ACC, OPC_MSR_ACC,
            OPC_CACHE_INV, OPC_HALT, OPC_CLR_TS: kernel_only = 1'b1;
            OPC_IO:        is_io = 1'b1;
            OPC_FLAGS_RST: is_flags_rst = 1'b1;
            default:       kernel_only = 1'b1;  // unassigned codes (R8)
        endcase
    end
endmodule

// File: rtl/io_perm_eval.sv
// Checks the bitmap window for the ports an I/O access covers.
module io_perm_eval #(
    parameter int WIN_W = 16
) (
    input  logic [2:0]       port_lo,
    input  logic [1:0]       size_code,
    input  logic [WIN_W-1:0] window,
    output logic             granted
);
    logic denied;
    int   span;

    always_comb begin
        case (size_code)
            2'd0:    span = 1;
            2'd1:    span = 2;
            default: span = 4;
        endcase
        denied = 1'b0;
        for (int i = 0; i < WIN_W; i++) begin
            if (i >= int'(port_lo) && i < int'(port_lo) + span)
                denied = denied | window[i];
        end
        granted = ~denied;
    end
endmodule

// File: rtl/flags_mask.sv
// Merges restored flags with the present ones, keeping the interrupt-enable bit below level 0.
module flags_mask #(
    parameter int FLAGS_W = 16,
    parameter int IE_BIT  = 9
) (
    input  logic               keep_ie,
    input  logic [FLAGS_W-1:0] flags_cur,
    input  logic [FLAGS_W-1:0] flags_src,
    output logic [FLAGS_W-1:0] flags_merged
);
    localparam logic [FLAGS_W-1:0] IE_MASK = FLAGS_W'(1) << IE_BIT;

    always_comb begin
        if (keep_ie)
            flags_merged = (flags_src & ~IE_MASK) | (flags_cur & IE_MASK);
        else
            flags_merged = flags_src;
    end
endmodule

// File: rtl/priv_op_checker.sv
module priv_op_checker
    import priv_chk_pkg::*;
#(
    parameter int PORT_W  = 16,
    parameter int FLAGS_W = 16,
    parameter int IE_BIT  = 9,
    parameter int VEC_W   = 8,
    parameter int ERR_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [3:0]         op_class,
    input  logic [1:0]         cur_lvl,
    input  logic [1:0]         io_lvl,
    input  logic [PORT_W-1:0]  io_port,
    input  logic [1:0]         io_size,
    output logic [PORT_W-4:0]  pbm_addr,
    input  logic [15:0]        pbm_data,
    input  logic [FLAGS_W-1:0] flags_cur,
    input  logic [FLAGS_W-1:0] flags_src,
    output logic               out_valid,
    output logic               allow,
    output logic               fault,
    output logic [VEC_W-1:0]   vector,
    output logic [ERR_W-1:0]   err_code,
    output logic               flags_wr,
    output logic [FLAGS_W-1:0] flags_out
);
    typedef struct packed {
        logic               vld;
        logic               allow;
        logic               fault;
        logic [VEC_W-1:0]   vec;
        logic [ERR_W-1:0]   err;
        logic               fwr;
        logic [FLAGS_W-1:0] flags;
    } dec_t;

    dec_t dec_d, dec_q;

    logic               kernel_only, is_io, is_flags_rst;
    logic               port_granted;
    logic [FLAGS_W-1:0] flags_merged;

    assign pbm_addr = io_port[PORT_W-1:3];

    priv_class_rule u_rule (
        .op_class     (op_class),
        .kernel_only  (kernel_only),
        .is_io        (is_io),
        .is_flags_rst (is_flags_rst)
    );

    io_perm_eval #(.WIN_W(16)) u_io (
        .port_lo   (io_port[2:0]),
        .size_code (io_size),
        .window    (pbm_data),
        .granted   (port_granted)
    );

    flags_mask #(.FLAGS_W(FLAGS_W), .IE_BIT(IE_BIT)) u_flags (
        .keep_ie      (cur_lvl != 2'd0),
        .flags_cur    (flags_cur),
        .flags_src    (flags_src),
        .flags_merged (flags_merged)
    );

    always_comb begin
        logic bad;
        dec_d = '0;
        bad   = 1'b0;
        if (kernel_only)
            bad = (cur_lvl != 2'd0);
        else if (is_io)
            bad = (cur_lvl > io_lvl) && !port_granted;
        if (in_valid) begin
            dec_d.vld   = 1'b1;
            dec_d.allow = !bad;
            dec_d.fault = bad;
            dec_d.vec   = bad ? VEC_W'(GP_VECTOR) : '0;
            dec_d.err   = bad ? ERR_W'(GP_ERROR) : '0;
            dec_d.fwr   = is_flags_rst;
            dec_d.flags = is_flags_rst ? flags_merged : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign out_valid = dec_q.vld;
    assign allow     = dec_q.allow;
    assign fault     = dec_q.fault;
    assign vector    = dec_q.vec;
    assign err_code  = dec_q.err;
    assign flags_wr  = dec_q.fwr;
    assign flags_out = dec_q.flags;

    // R9: exactly one verdict with a valid decision, none without
    p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({allow, fault}) == 1);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !allow && !fault && !flags_wr);
    // R2: fault carries general-protection vector and zero error code
    p_fault_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> vector == VEC_W'(13) && err_code == '0);
    p_allow_novec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        allow |-> vector == '0);
    // R1: level 0 is never refused
    p_kernel_allow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cur_lvl == 2'd0 |=> allow);
    // R5: descriptor table store allowed everywhere
    p_dt_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_class == 4'd4 |=> allow);
    // R6: flags restore never faults, IE kept below level 0
    p_flags_nofault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_class == 4'd11 |=> allow && flags_wr);
    p_flags_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_class == 4'd11 && cur_lvl != 2'd0
        |=> flags_out[IE_BIT] == $past(flags_cur[IE_BIT]));
endmodule

// File: tb/priv_op_checker_tb_top.sv
`timescale 1ns/1ps
module priv_op_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_class = '0;
    logic [1:0]  cur_lvl = '0;
    logic [1:0]  io_lvl = '0;
    logic [15:0] io_port = '0;
    logic [1:0]  io_size = '0;
    logic [12:0] pbm_addr;
    logic [15:0] pbm_data = '0;
    logic [15:0] flags_cur = '0;
    logic [15:0] flags_src = '0;
    logic        out_valid, allow, fault, flags_wr;
    logic [7:0]  vector;
    logic [15:0] err_code, flags_out;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    priv_op_checker dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
        .cur_lvl(cur_lvl), .io_lvl(io_lvl), .io_port(io_port), .io_size(io_size),
        .pbm_addr(pbm_addr), .pbm_data(pbm_data), .flags_cur(flags_cur),
        .flags_src(flags_src), .out_valid(out_valid), .allow(allow), .fault(fault),
        .vector(vector), .err_code(err_code), .flags_wr(flags_wr), .flags_out(flags_out)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [1:0]  lvl;
        logic [1:0]  iopl;
        logic [15:0] port;
        logic [1:0]  sz;
        logic [15:0] win;
        logic        ok;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{4'd0,  2'd3, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b1},
        '{4'd1,  2'd2, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b1},
        '{4'd2,  2'd0, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b1},
        '{4'd2,  2'd3, 2'd3, 16'h0000, 2'd0, 16'h0000, 1'b0},
        '{4'd5,  2'd1, 2'd3, 16'h0000, 2'd0, 16'h0000, 1'b0},
        '{4'd6,  2'd0, 2'd0, 16'h0000, 2'd0, 16'hffff, 1'b1},
        '{4'd7,  2'd2, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b0},
        '{4'd8,  2'd3, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b0},
        '{4'd9,  2'd1, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b0},
        '{4'd3,  2'd3, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b0},
        '{4'd4,  2'd3, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b1},
        '{4'd10, 2'd3, 2'd3, 16'h0060, 2'd0, 16'hffff, 1'b1},
        '{4'd10, 2'd2, 2'd3, 16'h0060, 2'd0, 16'hffff, 1'b1},
        '{4'd10, 2'd3, 2'd0, 16'h0060, 2'd0, 16'hfffe, 1'b1},
        '{4'd10, 2'd3, 2'd0, 16'h0061, 2'd0, 16'hfffe, 1'b0},
        '{4'd10, 2'd3, 2'd1, 16'h0066, 2'd1, 16'h0080, 1'b0},
        '{4'd10, 2'd3, 2'd1, 16'h0066, 2'd1, 16'hff3f, 1'b1},
        '{4'd10, 2'd1, 2'd0, 16'h0007, 2'd2, 16'hf87f, 1'b1},
        '{4'd10, 2'd1, 2'd0, 16'h0007, 2'd2, 16'hfc7f, 1'b0},
        '{4'd12, 2'd1, 2'd3, 16'h0000, 2'd0, 16'h0000, 1'b0},
        '{4'd15, 2'd0, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b1},
        '{4'd11, 2'd3, 2'd0, 16'h0000, 2'd0, 16'h0000, 1'b1}
    };

    function automatic string tag_for(logic [3:0] op);
        if (op <= 4'd1)   return "R7";
        if (op == 4'd4)   return "R5";
        if (op == 4'd10)  return "R3/R4";
        if (op == 4'd11)  return "R6";
        if (op >= 4'd12)  return "R8";
        return "R1";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Presents one operation and samples its decision 1 ns after the edge.
    task automatic issue(logic [3:0] op, logic [1:0] lvl, logic [1:0] iopl,
                         logic [15:0] port, logic [1:0] sz, logic [15:0] win);
        @(negedge clk);
        in_valid = 1'b1; op_class = op; cur_lvl = lvl; io_lvl = iopl;
        io_port = port; io_size = sz; pbm_data = win;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check("R10 out_valid", 32'(out_valid), 0);
        check("R10 allow/fault", 32'({allow, fault}), 0);
        check("R10 vector", 32'(vector), 0);
        check("R10 flags_wr", 32'(flags_wr), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].op, TBL[i].lvl, TBL[i].iopl, TBL[i].port, TBL[i].sz, TBL[i].win);
            check({tag_for(TBL[i].op), " allow"}, 32'(allow), 32'(TBL[i].ok));
            check({tag_for(TBL[i].op), " fault"}, 32'(fault), 32'(!TBL[i].ok));
            check("R2 vector", 32'(vector), TBL[i].ok ? 32'd0 : 32'd13);
            check("R2 err_code", 32'(err_code), 0);
            check("R9 out_valid", 32'(out_valid), 1);
        end

        // R9: cycle after no strobe
        @(negedge clk);
        @(posedge clk); #1;
        check("R9 idle out_valid", 32'(out_valid), 0);
        check("R9 idle verdict", 32'({allow, fault, flags_wr}), 0);

        // R4: bitmap address
        @(negedge clk); io_port = 16'h1234; #1;
        check("R4 pbm_addr", 32'(pbm_addr), 32'h246);

        // R6: flags masking
        flags_cur = 16'h0200; flags_src = 16'h0000;
        issue(4'd11, 2'd3, 2'd0, 16'h0, 2'd0, 16'h0);
        check("R6 keep IE set", 32'(flags_out), 32'h0200);
        check("R6 flags_wr", 32'(flags_wr), 1);
        flags_cur = 16'h0000; flags_src = 16'hffff;
        issue(4'd11, 2'd1, 2'd0, 16'h0, 2'd0, 16'h0);
        check("R6 keep IE clear", 32'(flags_out), 32'hfdff);
        issue(4'd11, 2'd0, 2'd0, 16'h0, 2'd0, 16'h0);
        check("R6 level0 full write", 32'(flags_out), 32'hffff);
        issue(4'd0, 2'd0, 2'd0, 16'h0, 2'd0, 16'h0);
        check("R6 no write for other class", 32'(flags_wr), 0);

        // R9: back-to-back strobes each get their own decision
        @(negedge clk);
        in_valid = 1'b1; op_class = 4'd8; cur_lvl = 2'd3;
        @(posedge clk); #1;
        check("R9 b2b first fault", 32'(fault), 1);
        op_class = 4'd0;
        @(posedge clk); #1;
        check("R9 b2b second allow", 32'(allow), 1);
        in_valid = 1'b0;
        @(posedge clk); #1;
        check("R9 b2b drop", 32'(out_valid), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #50000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule